// File: doc/BRIEF.md
# Paged Edge-Interrupt GPIO Controller

This block is a byte-wide register file that controls 48 digital lines arranged as six 8-bit ports. Each line has an open-drain style driver: a set data bit pulls the pin low, and a clear bit releases it so an external source can drive the line. A read of a port returns the live pin levels, taken through a two-flop synchronizer.

The lower 24 lines (ports 0 to 2) can raise interrupts. Each of these lines has three per-line controls: a polarity bit that picks the rising or the falling edge, an enable bit, and a latched identification flag. All three banks share one 3-byte window. A page field in a separate register selects which bank the window shows.

Software selects a page, then reads or writes the window. It clears the identification flags by writing ones to them. The single interrupt output is high while any identification flag is set.

Top module: `gpio_paged_irq`

## Requirements
- R1: After reset no pin is pulled low, the interrupt output is low, every enable, polarity and identification bit is 0, and the page field is 0.
- R2: A write to address p (0 to 5) loads the drive byte of port p onto pin_pull_low[8p+7:8p]; a 1 pulls the line low and a 0 releases it. Other ports keep their values.
- R3: A read of address p (0 to 5) returns the pin levels of port p as they stood before the second rising clock edge preceding the read; a pin change shows in the read data after exactly two edges.
- R4: Address 7 holds the page in bits 7:6 (0 none, 1 polarity, 2 enable, 3 identification); it reads back with bits 5:0 as zero.
- R5: Addresses 8, 9 and 10 form the window for ports 0, 1 and 2; with page 1 or page 2 selected, a byte written there reads back from the same address and page.
- R6: For an enabled line, a polarity bit of 1 latches the identification flag on a rising synchronized edge and a polarity bit of 0 on a falling one; the opposite edge does not set it. The flag is set three clock edges after the pin changes.
- R7: An edge on a line whose enable bit is 0 never sets its identification flag.
- R8: With page 3 selected, writing 1 to a window bit clears that flag and writing 0 leaves it unchanged. An edge that sets the flag on the same clock edge as the clear wins, and the flag stays set.
- R9: The interrupt output is high exactly while at least one identification flag of any port is set.
- R10: Address 6 reads 0x00 and ignores writes; addresses above 10 read 0x00.
- R11: With page 0 selected, the window reads 0x00 and writes to it change no bank.
- R12: Edges on ports 3 to 5 never raise the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| pin_in | input | 48 | Live pin levels |
| pin_pull_low | output | 48 | Per-line pull-low drive enables |
| irq | output | 1 | Interrupt, OR of all identification flags |

## Verification
The assertions assume that the pin inputs and the write strobe change only away from the rising clock edge. They also assume that writes happen only outside reset. The bench follows both rules: it changes every input on the falling edge and holds the write strobe for exactly one cycle. Nothing outside the block drives pin_pull_low, so the pin level is modelled as the external level ANDed with the inverted drive. The bench spaces pin edges at least three cycles apart, so each edge is latched before the next one arrives. The one exception is the clear-collision case, where the edge is deliberately placed on the same clock edge as the clear.

// File: rtl/gpio48_pkg.sv
package gpio48_pkg;

   // Bank shown in the shared window; the encoding is visible to software.
   typedef enum logic [1:0] {
      PG_NONE     = 2'd0,
      PG_POLARITY = 2'd1,
      PG_ENABLE   = 2'd2,
      PG_IDENT    = 2'd3
   } page_e;

   localparam int PAGE_W = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_sync: W must be positive");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic         pol_we,
   input  logic         en_we,
   input  logic         id_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] pol_q,
   output logic [W-1:0] en_q,
   output logic [W-1:0] id_q
);

   logic [W-1:0] prev_q;
   logic [W-1:0] rise_w, fall_w, hit_w, set_w, clr_w;

   assign rise_w = lvl & ~prev_q;
   assign fall_w = ~lvl & prev_q;
   assign hit_w  = (rise_w & pol_q) | (fall_w & ~pol_q);
   assign set_w  = hit_w & en_q;
   assign clr_w  = id_we ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         pol_q  <= '0;
         en_q   <= '0;
         id_q   <= '0;
      end else begin
         prev_q <= lvl;
         if (pol_we) pol_q <= wdata;
         if (en_we)  en_q  <= wdata;
         id_q <= (id_q & ~clr_w) | set_w;
      end
   end

   // A flag may only appear on a line that was enabled.
   p_enable_gate_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((id_q & ~$past(id_q) & ~$past(en_q)) == '0));

   // A detected edge always leaves its flag set, even with a clear pending.
   p_set_wins_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (($past(set_w) & ~id_q) == '0));

   // A clear with no colliding edge removes the flag.
   p_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ((id_q & $past(clr_w & ~set_w)) == '0));

   // Polarity and enable change only on their own strobes.
   p_cfg_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!pol_we && !en_we) |=> ($stable(pol_q) && $stable(en_q)));

endmodule

// File: rtl/gpio_paged_irq.sv
module gpio_paged_irq
   import gpio48_pkg::*;
#(
   parameter int NUM_PORTS   = 6,
   parameter int IRQ_PORTS   = 3,
   parameter int PORT_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [PORT_W-1:0]             wr_data,
   output logic [PORT_W-1:0]             rd_data,
   input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
   output logic [NUM_PORTS*PORT_W-1:0]   pin_pull_low,
   output logic                          irq
);

   localparam int NUM_LINES = NUM_PORTS * PORT_W;
   localparam int IRQ_LINES = IRQ_PORTS * PORT_W;
   localparam int RSVD_ADDR = NUM_PORTS;
   localparam int PAGE_ADDR = NUM_PORTS + 1;
   localparam int WIN_BASE  = NUM_PORTS + 2;
   localparam int WIN_END   = WIN_BASE + IRQ_PORTS;

   if (IRQ_PORTS < 1 || IRQ_PORTS > NUM_PORTS) begin : g_bad_irq_ports
      $error("gpio_paged_irq: IRQ_PORTS must lie in 1..NUM_PORTS");
   end
   if (PORT_W < PAGE_W + 1) begin : g_bad_port_w
      $error("gpio_paged_irq: PORT_W too narrow for the page field");
   end
   if (WIN_END > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("gpio_paged_irq: ADDR_W cannot reach the window");
   end

   // ------------------------------------------------------------ input sync
   logic [NUM_LINES-1:0] lvl_w;

   gpio_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (lvl_w)
   );

   // ------------------------------------------------------------ drive regs
   logic [PORT_W-1:0] drv_q [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (!rst_n)                              drv_q[p] <= '0;
         else if (wr_en && addr == ADDR_W'(p))    drv_q[p] <= wr_data;
      end
      assign pin_pull_low[p*PORT_W +: PORT_W] = drv_q[p];
   end

   // ------------------------------------------------------------ page reg
   page_e page_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         page_q <= PG_NONE;
      else if (wr_en && addr == ADDR_W'(PAGE_ADDR))
         page_q <= page_e'(wr_data[PORT_W-1 -: PAGE_W]);
   end

   // ------------------------------------------------------------ irq banks
   logic [PORT_W-1:0]    pol_a [IRQ_PORTS];
   logic [PORT_W-1:0]    en_a  [IRQ_PORTS];
   logic [PORT_W-1:0]    id_a  [IRQ_PORTS];
   logic [IRQ_LINES-1:0] id_flat;

   for (genvar i = 0; i < IRQ_PORTS; i++) begin : g_bank
      logic win_hit;
      assign win_hit = wr_en && (addr == ADDR_W'(WIN_BASE + i));

      gpio_irq_bank #(.W(PORT_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl    (lvl_w[i*PORT_W +: PORT_W]),
         .pol_we (win_hit && page_q == PG_POLARITY),
         .en_we  (win_hit && page_q == PG_ENABLE),
         .id_we  (win_hit && page_q == PG_IDENT),
         .wdata  (wr_data),
         .pol_q  (pol_a[i]),
         .en_q   (en_a[i]),
         .id_q   (id_a[i])
      );

      assign id_flat[i*PORT_W +: PORT_W] = id_a[i];
   end

   assign irq = |id_flat;

   // ------------------------------------------------------------ read mux
   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (addr == ADDR_W'(p)) rd_data = lvl_w[p*PORT_W +: PORT_W];
      end
      if (addr == ADDR_W'(PAGE_ADDR))
         rd_data = {page_q, {(PORT_W-PAGE_W){1'b0}}};
      for (int i = 0; i < IRQ_PORTS; i++) begin
         if (addr == ADDR_W'(WIN_BASE + i)) begin
            case (page_q)
               PG_POLARITY: rd_data = pol_a[i];
               PG_ENABLE:   rd_data = en_a[i];
               PG_IDENT:    rd_data = id_a[i];
               default:     rd_data = '0;
            endcase
         end
      end
   end

   // ------------------------------------------------------------ assertions
   logic in_win;
   assign in_win = (addr >= ADDR_W'(WIN_BASE)) && (addr < ADDR_W'(WIN_END));

   p_reserved_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(RSVD_ADDR)) |-> (rd_data == '0));

   p_page0_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && page_q == PG_NONE) |-> (rd_data == '0));

   p_drive_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(pin_pull_low));

   p_page_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> $stable(page_q));

endmodule

// File: tb/test_gpio_paged_irq.sv
`timescale 1ns/1ps
module test_gpio_paged_irq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [47:0] ext_lvl = '1;
   logic [47:0] pin_in;
   logic [47:0] pin_pull_low;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   // Open-drain pin: low when either side pulls it low.
   assign pin_in = ext_lvl & ~pin_pull_low;

   gpio_paged_irq i_gpio_paged_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .addr         (addr),
      .wr_data      (wr_data),
      .rd_data      (rd_data),
      .pin_in       (pin_in),
      .pin_pull_low (pin_pull_low),
      .irq          (irq)
   );

   task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; the register updates on the next rising edge.
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic set_page(input logic [1:0] pg);
      wr(8'd7, {pg, 6'b0});
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1: reset state
      chk("R1 pull_low", pin_pull_low, 48'h0);
      chk("R1 irq", {47'h0, irq}, 48'h0);
      rd(8'd7, v);  chk("R1 page", {40'h0, v}, 48'h0);
      set_page(2'd1);
      for (int q = 0; q < 3; q++) begin rd(8'(8 + q), v); chk("R1 polarity", {40'h0, v}, 48'h0); end
      set_page(2'd2);
      for (int q = 0; q < 3; q++) begin rd(8'(8 + q), v); chk("R1 enable", {40'h0, v}, 48'h0); end
      set_page(2'd3);
      for (int q = 0; q < 3; q++) begin rd(8'(8 + q), v); chk("R1 ident", {40'h0, v}, 48'h0); end
      set_page(2'd0);

      // R2 / R3: walk every drive bit
      for (int p = 0; p < 6; p++) begin
         for (int b = 0; b < 8; b++) begin
            wr(8'(p), 8'(1 << b));
            chk("R2 drive", pin_pull_low, 48'h1 << (p * 8 + b));
            tick(2);
            rd(8'(p), v);
            chk("R3 readback", {40'h0, v}, {40'h0, ~8'(1 << b)});
         end
         wr(8'(p), 8'h00);
         chk("R2 release", pin_pull_low, 48'h0);
      end
      tick(2);

      // R3: exact two-edge latency
      wr(8'd4, 8'h81);
      rd(8'd4, v); chk("R3 before first edge", {40'h0, v}, 48'hFF);
      tick(1);
      rd(8'd4, v); chk("R3 after one edge", {40'h0, v}, 48'hFF);
      tick(1);
      rd(8'd4, v); chk("R3 after two edges", {40'h0, v}, 48'h7E);
      wr(8'd4, 8'h00);
      tick(2);

      // R4: page register
      wr(8'd7, 8'hFF); rd(8'd7, v); chk("R4 page ff", {40'h0, v}, 48'hC0);
      wr(8'd7, 8'h7F); rd(8'd7, v); chk("R4 page 1", {40'h0, v}, 48'h40);
      wr(8'd7, 8'h3F); rd(8'd7, v); chk("R4 page 0", {40'h0, v}, 48'h00);

      // R5: window readback
      set_page(2'd1);
      wr(8'd8, 8'h3C); wr(8'd9, 8'hA5); wr(8'd10, 8'h0F);
      set_page(2'd2);
      wr(8'd8, 8'h11); wr(8'd9, 8'h22); wr(8'd10, 8'h44);
      set_page(2'd1);
      rd(8'd8, v);  chk("R5 pol0", {40'h0, v}, 48'h3C);
      rd(8'd9, v);  chk("R5 pol1", {40'h0, v}, 48'hA5);
      rd(8'd10, v); chk("R5 pol2", {40'h0, v}, 48'h0F);
      set_page(2'd2);
      rd(8'd8, v);  chk("R5 en0", {40'h0, v}, 48'h11);
      rd(8'd9, v);  chk("R5 en1", {40'h0, v}, 48'h22);
      rd(8'd10, v); chk("R5 en2", {40'h0, v}, 48'h44);

      // R11: page 0 window is inert
      set_page(2'd0);
      for (int q = 0; q < 3; q++) begin
         wr(8'(8 + q), 8'hFF);
         rd(8'(8 + q), v); chk("R11 page0 read", {40'h0, v}, 48'h0);
      end
      set_page(2'd1);
      rd(8'd9, v); chk("R11 polarity kept", {40'h0, v}, 48'hA5);
      set_page(2'd2);
      rd(8'd10, v); chk("R11 enable kept", {40'h0, v}, 48'h44);

      // R10: reserved and out-of-range addresses
      wr(8'd6, 8'hFF);
      rd(8'd6, v); chk("R10 reserved read", {40'h0, v}, 48'h0);
      chk("R10 reserved write no drive", pin_pull_low, 48'h0);
      rd(8'd7, v); chk("R10 reserved write no page", {40'h0, v}, 48'h80);
      rd(8'd11, v); chk("R10 addr 11", {40'h0, v}, 48'h0);
      rd(8'hFF, v); chk("R10 addr ff", {40'h0, v}, 48'h0);

      // R6: every interrupt line, both polarities
      for (int i = 0; i < 24; i++) begin
         for (int pol = 0; pol < 2; pol++) begin
            automatic int port = i / 8;
            automatic logic [7:0] m = 8'(1 << (i % 8));
            set_page(2'd1);
            wr(8'(8 + port), (pol == 1) ? m : 8'h00);
            set_page(2'd2);
            for (int q = 0; q < 3; q++) wr(8'(8 + q), (q == port) ? m : 8'h00);
            set_page(2'd3);
            for (int q = 0; q < 3; q++) wr(8'(8 + q), 8'hFF);
            ext_lvl[i] = 1'b0;
            tick(3);
            rd(8'(8 + port), v);
            chk("R6 falling edge flag", {40'h0, v}, {40'h0, (pol == 1) ? 8'h00 : m});
            chk("R9 irq after falling", {47'h0, irq}, {47'h0, pol == 0});
            wr(8'(8 + port), m);
            chk("R8 cleared irq", {47'h0, irq}, 48'h0);
            ext_lvl[i] = 1'b1;
            tick(3);
            rd(8'(8 + port), v);
            chk("R6 rising edge flag", {40'h0, v}, {40'h0, (pol == 1) ? m : 8'h00});
            chk("R9 irq after rising", {47'h0, irq}, {47'h0, pol == 1});
            wr(8'(8 + port), m);
            rd(8'(8 + port), v);
            chk("R8 cleared flag", {40'h0, v}, 48'h0);
         end
      end

      // R7: disabled lines never latch
      set_page(2'd2);
      for (int q = 0; q < 3; q++) wr(8'(8 + q), 8'h00);
      for (int pol = 0; pol < 2; pol++) begin
         set_page(2'd1);
         for (int q = 0; q < 3; q++) wr(8'(8 + q), (pol == 1) ? 8'hFF : 8'h00);
         ext_lvl[23:0] = '0;
         tick(3);
         chk("R7 disabled falling irq", {47'h0, irq}, 48'h0);
         ext_lvl[23:0] = '1;
         tick(3);
         chk("R7 disabled rising irq", {47'h0, irq}, 48'h0);
         set_page(2'd3);
         for (int q = 0; q < 3; q++) begin rd(8'(8 + q), v); chk("R7 disabled flag", {40'h0, v}, 48'h0); end
      end

      // R12: upper ports never interrupt
      set_page(2'd2);
      for (int q = 0; q < 3; q++) wr(8'(8 + q), 8'hFF);
      for (int pol = 0; pol < 2; pol++) begin
         set_page(2'd1);
         for (int q = 0; q < 3; q++) wr(8'(8 + q), (pol == 1) ? 8'hFF : 8'h00);
         ext_lvl[47:24] = '0;
         tick(3);
         chk("R12 upper falling", {47'h0, irq}, 48'h0);
         ext_lvl[47:24] = '1;
         tick(3);
         chk("R12 upper rising", {47'h0, irq}, 48'h0);
      end

      // R8 / R9: zero writes, two-port OR, clear collision
      set_page(2'd1);
      for (int q = 0; q < 3; q++) wr(8'(8 + q), 8'hFF);
      set_page(2'd2);
      for (int q = 0; q < 3; q++) wr(8'(8 + q), 8'h01);
      set_page(2'd3);
      ext_lvl[0] = 1'b0; ext_lvl[8] = 1'b0;
      tick(3);
      for (int q = 0; q < 3; q++) wr(8'(8 + q), 8'hFF);
      ext_lvl[0] = 1'b1; ext_lvl[8] = 1'b1;
      tick(3);
      rd(8'd8, v); chk("R6 port0 flag", {40'h0, v}, 48'h01);
      wr(8'd8, 8'h00);
      rd(8'd8, v); chk("R8 zero write keeps flag", {40'h0, v}, 48'h01);
      wr(8'd8, 8'h01);
      chk("R9 irq held by port1", {47'h0, irq}, 48'h1);
      rd(8'd9, v); chk("R9 port1 flag", {40'h0, v}, 48'h01);
      wr(8'd9, 8'h01);
      chk("R9 irq low when all clear", {47'h0, irq}, 48'h0);

      ext_lvl[0] = 1'b0;
      tick(3);
      ext_lvl[0] = 1'b1;
      tick(2);
      wr(8'd8, 8'h01);
      rd(8'd8, v); chk("R8 edge beats clear", {40'h0, v}, 48'h01);
      chk("R9 irq after collision", {47'h0, irq}, 48'h1);
      wr(8'd8, 8'h01);
      rd(8'd8, v); chk("R8 later clear", {40'h0, v}, 48'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule